// File: doc/BRIEF.md
# Multi-rate SDI data-valid cadence generator

This block drives the one-bit strobe that marks which clock cycles carry a parallel video word on a multi-rate SDI transmit or receive path. The strobe's high/low pattern depends on a 3-bit video standard code. A rate-mode flag tells the block whether the link runs single-rate or triple/multi-rate.

For standard definition the strobe follows an irregular eleven-cycle pattern with two valid words in each period. For high definition it either toggles every cycle or stays high, depending on the rate mode. For every faster standard it stays high. When the standard code changes, the pattern restarts at the beginning of its period on the next clock, so a new pattern never starts part-way through.

The strobe is registered. The block has no other outputs.

Top module: `sdi_valid_cadence`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, `data_valid` is low after that edge.
- R2: On the first rising edge with `rst` low after a reset, `data_valid` goes high. This is the first cycle of the selected pattern.
- R3: With code 000 (SD) held, `data_valid` repeats with an eleven-cycle period: high, four cycles low, high, five cycles low.
- R4: With code 001 (HD) and `multi_rate` = 1, `data_valid` alternates between one cycle high and one cycle low.
- R5: With code 001 (HD) and `multi_rate` = 0, `data_valid` stays high.
- R6: With any of the codes 010, 011, 100, 101, 110 and 111 (3G, 6G and 12G variants), `data_valid` stays high whatever `multi_rate` is.
- R7: When `std_code` differs from its value at the previous edge, `data_valid` is high after that edge. The new pattern then continues from the start of its period.
- R8: Only code 000 selects the SD pattern. Only code 001 depends on `multi_rate`, where 1 means triple/multi-rate and 0 means single-rate.
- R9: Over any 110 consecutive cycles that start at a pattern restart, the number of high cycles is 20 for SD, 55 for HD in multi-rate mode and 110 for every continuous mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| std_code | input | 3 | Video standard code |
| multi_rate | input | 1 | 1 = triple/multi-rate link, 0 = single-rate link |
| data_valid | output | 1 | Registered word-valid strobe |

## Verification
A wrong phase count shows up as a high cycle in the wrong place, or as a run of lows that is too long or too short. For SD this appears within one eleven-cycle period, and for alternating HD within two cycles. A stale copy of the standard code would suppress the restart. The stray low or the mid-period pattern then shows on the first edge after the code changes. Each pattern is compared cycle by cycle, and the high cycles are also counted over a full 110-cycle window for every code.

// File: rtl/sdi_valid_cadence.sv
module sdi_valid_cadence #(
  parameter int CODE_W    = 3,
  parameter int PHASE_W   = 4,
  parameter int SD_PERIOD = 11,
  parameter int SD_MARK   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] std_code,
  input  logic              multi_rate,
  output logic              data_valid
);
  localparam logic [CODE_W-1:0]  CODE_SD   = CODE_W'(0);
  localparam logic [CODE_W-1:0]  CODE_HD   = CODE_W'(1);
  localparam logic [PHASE_W-1:0] SD_LAST   = PHASE_W'(SD_PERIOD - 1);
  localparam logic [PHASE_W-1:0] SD_SECOND = PHASE_W'(SD_MARK);

  logic [PHASE_W-1:0] phase_q, last_phase, next_phase;
  logic [CODE_W-1:0]  code_q;
  logic               live_q, restart, next_valid;

  always_comb begin
    case (std_code)
      CODE_SD: last_phase = SD_LAST;
      CODE_HD: last_phase = multi_rate ? PHASE_W'(1) : '0;
      default: last_phase = '0;
    endcase
  end

  assign restart    = !live_q || (std_code != code_q);
  assign next_phase = (restart || phase_q >= last_phase) ? '0 : phase_q + PHASE_W'(1);

  always_comb begin
    if (std_code == CODE_SD)
      next_valid = (next_phase == '0) || (next_phase == SD_SECOND);
    else if (std_code == CODE_HD && multi_rate)
      next_valid = (next_phase == '0);
    else
      next_valid = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= '0;
      code_q     <= '0;
      live_q     <= 1'b0;
      data_valid <= 1'b0;
    end else begin
      phase_q    <= next_phase;
      code_q     <= std_code;
      live_q     <= 1'b1;
      data_valid <= next_valid;
    end
  end
endmodule

module sdi_valid_cadence_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] std_code,
  input logic       multi_rate,
  input logic       data_valid
);
  logic is_sd, hd_alt;
  assign is_sd  = (std_code == 3'b000);
  assign hd_alt = (std_code == 3'b001) && multi_rate;

  // R1
  reset_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !data_valid);

  // R2
  first_high_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> data_valid);

  // R7
  restart_high_chk: assert property (@(posedge clk) disable iff (rst)
    (std_code != $past(std_code)) |=> data_valid);

  // R6
  fast_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (std_code[2] || std_code[1]) |=> data_valid);

  // R5
  hd_single_chk: assert property (@(posedge clk) disable iff (rst)
    (std_code == 3'b001 && !multi_rate) |=> data_valid);

  // R4
  hd_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (hd_alt && $past(hd_alt) && !$past(rst)) |=> (data_valid != $past(data_valid)));

  // R3
  sd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (is_sd && $past(is_sd) && !$past(rst) && data_valid) |=> !data_valid);
endmodule

bind sdi_valid_cadence sdi_valid_cadence_chk u_chk (
  .clk(clk), .rst(rst), .std_code(std_code),
  .multi_rate(multi_rate), .data_valid(data_valid)
);

// File: tb/sdi_valid_cadence_bench.sv
module sdi_valid_cadence_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] std_code = 3'b000;
  logic       multi_rate = 1'b1;
  logic       data_valid;

  typedef struct { bit v; string tag; } exp_t;
  exp_t exp_q[$];

  int compared = 0, mismatched = 0, win_hi = 0;
  bit m_live = 0;
  logic [2:0] m_std = 3'b000;
  int m_pos = 0;

  always #5 clk = ~clk;

  sdi_valid_cadence u_sdi_valid_cadence (
    .clk(clk), .rst(rst), .std_code(std_code),
    .multi_rate(multi_rate), .data_valid(data_valid)
  );

  function automatic int period(input logic [2:0] s, input bit m);
    if (s == 3'b000) return 11;
    if (s == 3'b001 && m) return 2;
    return 1;
  endfunction

  function automatic bit high_at(input logic [2:0] s, input bit m, input int p);
    if (s == 3'b000) return (p == 0 || p == 5);
    if (s == 3'b001 && m) return (p == 0);
    return 1'b1;
  endfunction

  function automatic string tag_for(input logic [2:0] s, input bit m);
    if (s == 3'b000) return "R3";
    if (s == 3'b001) return m ? "R4" : "R5";
    return "R6";
  endfunction

  task automatic step(input bit r, input logic [2:0] s, input bit m);
    exp_t e;
    @(negedge clk);
    rst = r; std_code = s; multi_rate = m;
    if (r) begin
      m_live = 0;
      e.v = 1'b0; e.tag = "R1";
    end else begin
      if (!m_live) begin m_pos = 0; e.tag = "R2"; end
      else if (s != m_std) begin m_pos = 0; e.tag = "R7"; end
      else begin
        m_pos = (m_pos + 1) % period(s, m);
        e.tag = tag_for(s, m);
      end
      m_live = 1; m_std = s;
      e.v = high_at(s, m, m_pos);
    end
    exp_q.push_back(e);
  endtask

  task automatic run(input int n, input logic [2:0] s, input bit m);
    for (int i = 0; i < n; i++) step(1'b0, s, m);
  endtask

  // R9 (with R8 code selection): count highs over 110 cycles from a restart
  task automatic window(input logic [2:0] s, input bit m, input int exp_hi);
    wait (exp_q.size() == 0);
    win_hi = 0;
    run(110, s, m);
    wait (exp_q.size() == 0);
    #1;
    compared++;
    if (win_hi != exp_hi) begin
      mismatched++;
      $display("FAIL R9/R8 code=%b mr=%0b: high count %0d, expected %0d", s, m, win_hi, exp_hi);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        compared++;
        if (data_valid !== exp_q[0].v) begin
          mismatched++;
          $display("FAIL %s at %0t: data_valid=%b expected %b", exp_q[0].tag, $time, data_valid, exp_q[0].v);
        end
        if (data_valid === 1'b1) win_hi++;
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 3; i++) step(1'b1, 3'b000, 1'b1);   // R1
    run(23, 3'b000, 1'b1);                                  // R2 then R3
    window(3'b000, 1'b0, 20);
    window(3'b001, 1'b1, 55);
    window(3'b001, 1'b0, 110);
    window(3'b011, 1'b1, 110);
    window(3'b010, 1'b0, 110);
    window(3'b101, 1'b1, 110);
    window(3'b100, 1'b0, 110);
    window(3'b111, 1'b1, 110);
    window(3'b110, 1'b0, 110);
    window(3'b000, 1'b1, 20);
    // R7: mid-period code changes
    run(3, 3'b000, 1'b1);
    run(3, 3'b001, 1'b1);
    run(8, 3'b000, 1'b1);
    run(2, 3'b011, 1'b0);
    run(14, 3'b000, 1'b0);
    // R1 / R2: reset in the middle of a pattern
    step(1'b1, 3'b000, 1'b0);
    step(1'b1, 3'b001, 1'b1);
    run(6, 3'b001, 1'b1);
    wait (exp_q.size() == 0);
    #1;
    finish_run();
  end
endmodule